// File: doc/BRIEF.md
# Two-Wire Controlled Digital Potentiometer Target

This block is the serial control side of a 64-step digital potentiometer. It watches a two-wire bus (SCL/SDA), oversampled by the system clock. It answers a 7-bit device address whose two low bits come from strap pins, and it obeys a one-byte instruction that selects a command. The state it keeps is a 6-bit wiper register, a shadow register that models nonvolatile storage with a fixed programming time, a write-protect flag and two read-only tolerance bytes.

A write transaction is made of the address byte, the instruction byte and, for write commands, one or more data bytes. The store and restore commands need no data byte. To read, the host first sends a dummy write of the address and a read instruction. It then sends a repeated START and the address with the read bit set. The target then shifts out the selected byte and continues until the host answers with a NACK. The wiper value is available on a port for the analog stage.

Top module: `dpot_i2c_target`

## Requirements
- R1: The device address is {ADDR_BASE (default 5'b01011), strap_i[1:0]}, with strap_i sampled only during reset. An address byte is seven address bits MSB first followed by a direction bit (1 = read). A byte naming another address gets no acknowledge, and strap changes after reset have no effect.
- R2: The target pulls SDA low for the ninth SCL pulse after a matching address byte, after an accepted instruction byte and after each write data byte, and at no other acknowledge slot.
- R3: Instruction bits [7:5] are the command: 000 NOP, 001 write wiper, 010 write shadow, 011 protect control, 100 store, 101 restore, 110 read wiper, 111 read shadow then tolerance. If bits [4:0] are not all zero, the instruction is NACKed and has no effect.
- R4: After a write-wiper instruction, every data byte until STOP loads data[5:0] into the wiper. The upper data bits are ignored.
- R5: A protect-control data byte sets protection when bit 0 is 1 and clears it when bit 0 is 0. The byte itself is stored nowhere.
- R6: While protection is on, write-wiper, write-shadow and store are acknowledged but change nothing and start no programming time.
- R7: Write-shadow loads data[5:0] into the shadow, and store copies the wiper into it. Either one holds busy_o high for EE_CYCLES clocks, and the new shadow value is readable after that.
- R8: Restore copies the shadow value into the wiper.
- R9: While busy_o is high, any instruction other than NOP is NACKed and has no effect. NOP is acknowledged.
- R10: After reset the wiper and the shadow both hold midscale (32), protection is off, busy_o is low and SDA is released.
- R11: After instruction 110, a read returns {2'b00, wiper}, MSB first. Each further byte that the host acknowledges returns the wiper again, and a NACK ends the read.
- R12: After instruction 111, successive read bytes are the shadow, then TOL_HI (default 8'h05), then TOL_LO (default 8'h80). The last byte repeats after that.
- R13: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset; the strap pins are sampled while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Address strap pins that select the two low address bits |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wiper_o | output | 6 | Current wiper position |
| busy_o | output | 1 | Shadow programming in progress |

## Verification
The assertions assume a well-formed bus. SCL and SDA each stay level for several system clocks, and SDA changes only while SCL is low, except to form START and STOP. Under these conditions the target's own drive never collides with a START or STOP of its own making. The bench holds each bus phase for five system clocks. It moves SDA only in the middle of SCL-low phases and releases SDA in every slot that belongs to the target, so the synchronizer delay never reorders edges.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_WR_WIP  = 3'd1,
    CMD_WR_SHD  = 3'd2,
    CMD_PROTECT = 3'd3,
    CMD_STORE   = 3'd4,
    CMD_RESTORE = 3'd5,
    CMD_RD_WIP  = 3'd6,
    CMD_RD_SHD  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_SKIP
  } phase_e;

  // Instruction is well formed when its five low bits are clear.
  function automatic logic instr_wellformed(input logic [7:0] b);
    return b[4:0] == 5'd0;
  endfunction

  function automatic logic cmd_takes_data(input cmd_e c);
    return (c == CMD_WR_WIP) || (c == CMD_WR_SHD) || (c == CMD_PROTECT);
  endfunction

  // Byte returned on a read, by mode and read pointer.
  function automatic logic [7:0] read_pick(input logic ext, input logic [1:0] ptr,
                                           input logic [7:0] wip, input logic [7:0] shd,
                                           input logic [7:0] t_hi, input logic [7:0] t_lo);
    if (!ext)           return wip;
    else if (ptr == 2'd0) return shd;
    else if (ptr == 2'd1) return t_hi;
    else                return t_lo;
  endfunction

  function automatic logic [1:0] ptr_advance(input logic ext, input logic [1:0] ptr);
    if (!ext || ptr == 2'd2) return ptr;
    return ptr + 2'd1;
  endfunction

endpackage

// File: rtl/dpot_busmon.sv
`timescale 1ns/1ps
module dpot_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl_o      = scl_sy[1];
  assign sda_o      = sda_sy[1];
  assign scl_rise_o = scl_sy[1] & ~scl_d;
  assign scl_fall_o = ~scl_sy[1] & scl_d;
  assign start_o    = scl_sy[1] & scl_d & sda_d & ~sda_sy[1];
  assign stop_o     = scl_sy[1] & scl_d & ~sda_d & sda_sy[1];
endmodule

// File: rtl/dpot_regs.sv
`timescale 1ns/1ps
module dpot_regs #(
  parameter int W         = 6,
  parameter int EE_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_wip_i,
  input  logic         wr_shd_i,
  input  logic         prot_wr_i,
  input  logic         prot_val_i,
  input  logic         store_i,
  input  logic         restore_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] wiper_o,
  output logic [W-1:0] shadow_o,
  output logic         busy_o
);
  localparam int CW = $clog2(EE_CYCLES + 1);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0]  wiper_q, shadow_q, pend_q;
  logic [CW-1:0] left_q;
  logic          prot_q;
  logic          prog_go;

  assign prog_go = (wr_shd_i | store_i) & ~prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q  <= MID;
      shadow_q <= MID;
      pend_q   <= MID;
      left_q   <= '0;
      prot_q   <= 1'b0;
    end else begin
      if (wr_wip_i && !prot_q) wiper_q <= data_i;
      else if (restore_i)      wiper_q <= shadow_q;
      if (prot_wr_i) prot_q <= prot_val_i;
      if (prog_go) begin
        pend_q <= wr_shd_i ? data_i : wiper_q;
        left_q <= CW'(EE_CYCLES);
      end else if (left_q != '0) begin
        left_q <= left_q - CW'(1);
        if (left_q == CW'(1)) shadow_q <= pend_q;
      end
    end
  end

  assign wiper_o  = wiper_q;
  assign shadow_o = shadow_q;
  assign busy_o   = left_q != '0;

  assert_prot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !restore_i) |=> $stable(wiper_q));
  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_shd_i || store_i));
  assert_cmd_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_wip_i, wr_shd_i, prot_wr_i, store_i, restore_i}));
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(wr_wip_i || wr_shd_i || prot_wr_i || store_i || restore_i));
endmodule

// File: rtl/dpot_i2c_target.sv
`timescale 1ns/1ps
module dpot_i2c_target
  import dpot_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b01011,
  parameter int         W         = 6,
  parameter int         EE_CYCLES = 1000,
  parameter logic [7:0] TOL_HI    = 8'h05,
  parameter logic [7:0] TOL_LO    = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic [1:0]   strap_i,
  output logic         sda_low_o,
  output logic [W-1:0] wiper_o,
  output logic         busy_o
);
  localparam int BITS = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  dpot_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  phase_e      st;
  logic [3:0]  cnt;
  logic [6:0]  sh;
  logic        ack_pend, sda_low, rw_q, rd_ext;
  logic [1:0]  strap_q, ptr;
  cmd_e        cmd;
  logic [7:0]  tx;

  logic [7:0]  byte_in;
  logic        byte_done, ack_rise, addr_hit, instr_accept;
  cmd_e        cmd_in;
  logic [W-1:0] shadow;
  logic        busy;
  logic [7:0]  rd_val;
  logic [1:0]  ptr_nxt;
  logic        fall_drive;

  assign byte_in      = {sh, sda_s};
  assign byte_done    = scl_rise && (cnt == 4'd7);
  assign ack_rise     = scl_rise && (cnt == 4'd8);
  assign addr_hit     = byte_in[7:1] == {ADDR_BASE, strap_q};
  assign cmd_in       = cmd_e'(byte_in[7:5]);
  assign instr_accept = instr_wellformed(byte_in) && (!busy || cmd_in == CMD_NOP);
  assign rd_val       = read_pick(rd_ext, ptr, 8'(wiper_o), 8'(shadow), TOL_HI, TOL_LO);
  assign ptr_nxt      = ptr_advance(rd_ext, ptr);

  // Single-cycle command strobes towards the register file.
  logic wr_wip, wr_shd, prot_wr, do_store, do_restore;
  assign wr_wip     = byte_done && st == ST_WDATA && cmd == CMD_WR_WIP;
  assign wr_shd     = byte_done && st == ST_WDATA && cmd == CMD_WR_SHD;
  assign prot_wr    = byte_done && st == ST_WDATA && cmd == CMD_PROTECT;
  assign do_store   = byte_done && st == ST_INSTR && instr_accept && cmd_in == CMD_STORE;
  assign do_restore = byte_done && st == ST_INSTR && instr_accept && cmd_in == CMD_RESTORE;

  dpot_regs #(.W(W), .EE_CYCLES(EE_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_wip_i(wr_wip), .wr_shd_i(wr_shd), .prot_wr_i(prot_wr), .prot_val_i(byte_in[0]),
    .store_i(do_store), .restore_i(do_restore), .data_i(byte_in[W-1:0]),
    .wiper_o(wiper_o), .shadow_o(shadow), .busy_o(busy)
  );

  always_comb begin
    case (st)
      ST_ADDR, ST_INSTR, ST_WDATA: fall_drive = (cnt == 4'd8) && ack_pend;
      ST_RDATA: fall_drive = (cnt != 4'd8) && !tx[3'd7 - cnt[2:0]];
      default:  fall_drive = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ack_pend <= 1'b0; sda_low <= 1'b0;
      rw_q <= 1'b0; rd_ext <= 1'b0; ptr <= '0; cmd <= CMD_NOP; tx <= '0;
      strap_q <= strap_i;
    end else if (bus_start) begin
      st <= ST_ADDR; cnt <= '0; sda_low <= 1'b0;
    end else if (bus_stop) begin
      st <= ST_IDLE; cnt <= '0; sda_low <= 1'b0;
    end else begin
      if (scl_rise && st != ST_IDLE) begin
        if (cnt != 4'd8) begin
          cnt <= cnt + 4'd1;
          sh  <= byte_in[6:0];
        end else cnt <= '0;
        if (byte_done) begin
          case (st)
            ST_ADDR:  begin ack_pend <= addr_hit; rw_q <= sda_s; end
            ST_INSTR: begin
              ack_pend <= instr_accept;
              if (instr_accept) begin
                cmd <= cmd_in; rd_ext <= (cmd_in == CMD_RD_SHD); ptr <= '0;
              end
            end
            ST_WDATA: ack_pend <= 1'b1;
            default:  ack_pend <= 1'b0;
          endcase
        end
        if (ack_rise) begin
          case (st)
            ST_ADDR:
              if (!ack_pend) st <= ST_SKIP;
              else if (rw_q) begin st <= ST_RDATA; tx <= rd_val; ptr <= ptr_nxt; end
              else st <= ST_INSTR;
            ST_INSTR: st <= (ack_pend && cmd_takes_data(cmd)) ? ST_WDATA : ST_SKIP;
            ST_WDATA: st <= (cmd == CMD_WR_WIP) ? ST_WDATA : ST_SKIP;
            ST_RDATA:
              if (sda_s) st <= ST_SKIP;
              else begin tx <= rd_val; ptr <= ptr_nxt; end
            default: ;
          endcase
        end
      end
      if (scl_fall) sda_low <= fall_drive;
    end
  end

  assign sda_low_o = sda_low;
  assign busy_o    = busy;

  assert_drive_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_s);
  assert_ack_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && (st == ST_ADDR || st == ST_INSTR || st == ST_WDATA)) |-> cnt == 4'd8);
endmodule

// File: tb/dpot_i2c_target_tb.sv
`timescale 1ns/1ps
module dpot_i2c_target_tb;
  localparam int Q = 100;
  localparam logic [7:0] AW = 8'h5C, AR = 8'h5D, A_OTHER = 8'h58;
  localparam int NV = 14;
  // {op[26:25], ack[24], instr[23:16], data[15:8], exp[7:0]}; op 0=write+data, 1=cmd only, 2=read
  localparam logic [26:0] VEC [NV] = '{
    {2'd2, 1'b1, 8'hC0, 8'h00, 8'h20},
    {2'd0, 1'b1, 8'h20, 8'h15, 8'h15},
    {2'd0, 1'b1, 8'h20, 8'hFF, 8'h3F},
    {2'd2, 1'b1, 8'hC0, 8'h00, 8'h3F},
    {2'd2, 1'b1, 8'hE0, 8'h00, 8'h20},
    {2'd1, 1'b1, 8'hA0, 8'h00, 8'h20},
    {2'd0, 1'b1, 8'h20, 8'h07, 8'h07},
    {2'd0, 1'b1, 8'h60, 8'h01, 8'h07},
    {2'd0, 1'b1, 8'h20, 8'h11, 8'h07},
    {2'd1, 1'b1, 8'h80, 8'h00, 8'h07},
    {2'd0, 1'b1, 8'h60, 8'h00, 8'h07},
    {2'd1, 1'b0, 8'h21, 8'h00, 8'h07},
    {2'd2, 1'b1, 8'hE0, 8'h00, 8'h20},
    {2'd1, 1'b1, 8'h00, 8'h00, 8'h07}
  };
  string tags [NV] = '{"R10", "R4", "R4", "R11", "R12", "R8", "R4", "R5",
                       "R6", "R6", "R5", "R3", "R6", "R3"};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_low, busy;
  logic [5:0] wiper;
  wire sda_ln = sda_m & ~sda_low;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpot_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .strap_i(strap),
    .sda_low_o(sda_low), .wiper_o(wiper), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic bstop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; ack = ~sda_ln; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic rbyte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl_m = 1'b1; #Q; b[i] = sda_ln; #Q; scl_m = 1'b0; #Q;
    end
    sda_m = nack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    logic [26:0] v;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk("R10 wiper", wiper, 32);
    chk("R10 busy", busy, 0);
    chk("R10 sda", sda_low, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      bstart();
      wbyte(AW, a);       chk({tags[i], " addr ack R2"}, a, 1);
      wbyte(v[23:16], a); chk({tags[i], " instr ack R2"}, a, v[24]);
      case (v[26:25])
        2'd0: begin
          wbyte(v[15:8], a); chk({tags[i], " data ack R2"}, a, 1);
          bstop(); chk({tags[i], " wiper"}, wiper, v[7:0]);
        end
        2'd1: begin bstop(); chk({tags[i], " wiper"}, wiper, v[7:0]); end
        default: begin
          bstart(); wbyte(AR, a); chk({tags[i], " read addr ack R11"}, a, 1);
          rbyte(1'b1, b); bstop(); chk({tags[i], " read byte"}, b, v[7:0]);
        end
      endcase
    end

    // R4: wiper streaming within one transaction
    bstart(); wbyte(AW, a); wbyte(8'h20, a);
    wbyte(8'h01, a); chk("R4 stream 1", wiper, 1);
    wbyte(8'h02, a); chk("R4 stream 2", wiper, 2);
    wbyte(8'h43, a); chk("R4 stream 3", wiper, 3);
    bstop();

    // R11: repeated wiper read
    bstart(); wbyte(AW, a); wbyte(8'hC0, a); bstart(); wbyte(AR, a);
    rbyte(1'b0, b); chk("R11 first", b, 3);
    rbyte(1'b1, b); chk("R11 repeat", b, 3);
    bstop(); chk("R11 released", sda_low, 0);

    // R1: foreign address, strap latched at reset
    bstart(); wbyte(A_OTHER, a); bstop(); chk("R1 other addr nack", a, 0);
    strap = 2'b00;
    bstart(); wbyte(A_OTHER, a); bstop(); chk("R1 strap change ignored", a, 0);
    bstart(); wbyte(AW, a); chk("R1 latched addr ack", a, 1);
    wbyte(8'h20, a); wbyte(8'h09, a); bstop(); chk("R1 write", wiper, 9);
    strap = 2'b10;

    // R7 / R9: shadow write, busy window
    bstart(); wbyte(AW, a); wbyte(8'h40, a); wbyte(8'hEA, a); bstop();
    chk("R7 busy set", busy, 1);
    bstart(); wbyte(AW, a); wbyte(8'h20, a); chk("R9 nack when busy", a, 0);
    wbyte(8'h15, a); bstop(); chk("R9 no effect", wiper, 9);
    bstart(); wbyte(AW, a); wbyte(8'h00, a); bstop(); chk("R9 nop ack", a, 1);
    #(1100 * 20);
    chk("R7 busy clear", busy, 0);

    // R12: shadow then tolerance bytes
    bstart(); wbyte(AW, a); wbyte(8'hE0, a); bstart(); wbyte(AR, a);
    rbyte(1'b0, b); chk("R12 shadow", b, 8'h2A);
    rbyte(1'b0, b); chk("R12 tol hi", b, 8'h05);
    rbyte(1'b0, b); chk("R12 tol lo", b, 8'h80);
    rbyte(1'b1, b); chk("R12 tol lo repeat", b, 8'h80);
    bstop();

    // R8 restore, R7 store
    bstart(); wbyte(AW, a); wbyte(8'hA0, a); bstop(); chk("R8 restore", wiper, 8'h2A);
    bstart(); wbyte(AW, a); wbyte(8'h20, a); wbyte(8'h11, a); bstop();
    bstart(); wbyte(AW, a); wbyte(8'h80, a); bstop(); chk("R7 store busy", busy, 1);
    #(1100 * 20);
    bstart(); wbyte(AW, a); wbyte(8'hE0, a); bstart(); wbyte(AR, a);
    rbyte(1'b1, b); bstop(); chk("R7 store value", b, 8'h11);

    // R6: shadow write under protection
    bstart(); wbyte(AW, a); wbyte(8'h60, a); wbyte(8'h01, a); bstop();
    bstart(); wbyte(AW, a); wbyte(8'h40, a); wbyte(8'h05, a); bstop();
    chk("R6 no busy", busy, 0);
    bstart(); wbyte(AW, a); wbyte(8'h60, a); wbyte(8'h00, a); bstop();
    bstart(); wbyte(AW, a); wbyte(8'hE0, a); bstart(); wbyte(AR, a);
    rbyte(1'b1, b); bstop(); chk("R6 shadow kept", b, 8'h11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule